// File: doc/BRIEF.md
# Page Load Buffer with Idle-Timeout Commit

This block is the byte-load front end of a page-programmed non-volatile store. A host sends write strobes with active-low chip enable, write enable and output enable. Each strobe carries a 17-bit address and a data byte. The low seven address bits pick a byte inside a 128-byte page, and the upper bits pick the page. Accepted bytes go into a page buffer, and a valid mask records which positions were written. Bytes may arrive in any order.

The page stays open while bytes keep arriving. Each accepted byte restarts an idle timer. When the timer expires, the block stops accepting bytes and raises `busy` for a fixed programming time. At the end of that time all 128 positions are written into a behavioural array in one cycle. Positions the host did not load are written as FFh. The array holds `ARR_PAGES` pages, and a page number maps onto the array as that number modulo `ARR_PAGES`. Its contents can be read combinationally through `rd_addr`.

The controller has three states:
- `ST_IDLE`: no page is open. The first accepted byte moves it to `ST_LOAD` (transition *open*).
- `ST_LOAD`: the page is open. Matching bytes keep it there (transition *extend*). After `TIMEOUT` cycles with no accepted byte it moves to `ST_PROG` (transition *expire*).
- `ST_PROG`: the commit is in progress. After `PROG_CYC` cycles it returns to `ST_IDLE` (transition *commit*).

Top module: `page_load_buf`

## Requirements
- R1: After reset `busy` and `page_err` are 0 and every array location reads FFh.
- R2: A strobe is active only while `ce_n`=0, `we_n`=0 and `oe_n`=1. With `oe_n`=0, or with `ce_n`=1, no byte is loaded and no page is opened.
- R3: Address bits [6:0] select the byte and bits [16:7] select the page (array slot = page mod `ARR_PAGES`). Bytes loaded in any order land at their own offsets.
- R4: Any position of the committed page that received no byte reads FFh after the commit.
- R5: Every accepted byte restarts the idle timer. `busy` rises `TIMEOUT` cycles after the last accepted byte, and not earlier.
- R6: `busy` stays high for exactly `PROG_CYC` cycles. All buffered bytes appear in the array when it falls.
- R7: A byte whose page differs from the open page is dropped. It sets `page_err`, which stays 1 until reset, and it does not restart the timer.
- R8: Strobes that finish while `busy` is 1 are ignored and do not open a new page.
- R9: The valid mask is cleared at commit. Bytes from an earlier page are not carried into the next one.
- R10: The address is captured when a strobe starts, and the data is captured when the strobe ends. Later address changes and earlier data values during the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | 17 | Write address: page in [16:7], byte in [6:0] |
| din | input | 8 | Write data byte |
| rd_addr | input | 17 | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` |
| busy | output | 1 | High during the internal programming cycle |
| page_err | output | 1 | Sticky flag for a byte sent to the wrong page |

## Verification
Some internal faults show up at the ports only late:
- A valid mask that is wrong, or not cleared, shows up only after the next commit, as an FFh where data was expected or stale data where FFh was expected.
- A timer that is not restarted, or that is wrongly restarted by a dropped byte, moves the rise of `busy` by hundreds of cycles. This is seen at the first expiry.

Some faults show up quickly:
- A wrong state after a strobe during `busy` shows up as a second `busy` pulse within one timeout window.
- Mis-latched address or data appears as a misplaced byte when the array is read right after `busy` falls.

// File: rtl/pl_pkg.sv
package pl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pl_state_e;
endpackage

// File: rtl/pl_strobe.sv
module pl_strobe #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              byte_evt,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0] byte_data
);
    logic act_now, act_q, act_d;
    logic [DATA_W-1:0] din_q;
    logic [ADDR_W-1:0] addr_lat;

    assign act_now = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            act_d    <= 1'b0;
            din_q    <= '0;
            addr_lat <= '0;
        end else begin
            act_q <= act_now;
            act_d <= act_q;
            din_q <= din;
            if (act_q && !act_d)
                addr_lat <= addr;
        end
    end

    assign byte_evt  = act_d && !act_q;
    assign byte_addr = addr_lat;
    assign byte_data = din_q;
endmodule

// File: rtl/pl_ctrl.sv
module pl_ctrl
    import pl_pkg::*;
#(
    parameter int PG_W     = 10,
    parameter int TIMEOUT  = 300,
    parameter int PROG_CYC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_evt,
    input  logic [PG_W-1:0] byte_page,
    output logic            accept,
    output logic            commit,
    output logic [PG_W-1:0] open_page,
    output logic            busy,
    output logic            page_err
);
    localparam int MAXC  = (TIMEOUT > PROG_CYC) ? TIMEOUT : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    pl_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q;
    logic [PG_W-1:0]  page_q;
    logic             err_q, mism;

    always_comb begin
        state_n = state_q;
        accept  = 1'b0;
        commit  = 1'b0;
        mism    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (byte_evt) begin
                    accept  = 1'b1;
                    state_n = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (byte_evt && byte_page == page_q) accept = 1'b1;
                else if (byte_evt)                   mism   = 1'b1;
                if (!accept && cnt_q == CNT_W'(TIMEOUT - 1))
                    state_n = ST_PROG;
            end
            ST_PROG: begin
                if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
                    commit  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            page_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (accept || state_n != state_q || state_q == ST_IDLE)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
            if (accept && state_q == ST_IDLE)
                page_q <= byte_page;
            if (mism)
                err_q <= 1'b1;
        end
    end

    assign open_page = page_q;
    assign busy      = (state_q == ST_PROG);
    assign page_err  = err_q;

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/pl_buf.sv
module pl_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept,
    input  logic                         commit,
    input  logic [OFF_W-1:0]             off,
    input  logic [DATA_W-1:0]            data,
    output logic [PAGE_BYTES-1:0]        vmask,
    output logic [PAGE_BYTES*DATA_W-1:0] bytes_flat
);
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vmask[i]                        <= 1'b0;
                bytes_flat[i*DATA_W +: DATA_W] <= '0;
            end else if (commit) begin
                vmask[i] <= 1'b0;
            end else if (accept && off == OFF_W'(i)) begin
                vmask[i]                        <= 1'b1;
                bytes_flat[i*DATA_W +: DATA_W] <= data;
            end
        end
    end
endmodule

// File: rtl/pl_array.sv
module pl_array #(
    parameter int PAGE_BYTES = 128,
    parameter int ARR_PAGES  = 8,
    parameter int DATA_W     = 8,
    parameter int PG_W       = 10,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [PG_W-1:0]              wr_page,
    input  logic [PAGE_BYTES-1:0]        vmask,
    input  logic [PAGE_BYTES*DATA_W-1:0] bytes_flat,
    input  logic [PG_W-1:0]              rd_page,
    input  logic [OFF_W-1:0]             rd_off,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int AP_W = (ARR_PAGES > 1) ? $clog2(ARR_PAGES) : 1;

    logic [DATA_W-1:0] mem [ARR_PAGES][PAGE_BYTES];
    logic [AP_W-1:0]   wslot, rslot;

    assign wslot = AP_W'(wr_page % PG_W'(ARR_PAGES));
    assign rslot = AP_W'(rd_page % PG_W'(ARR_PAGES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < ARR_PAGES; p++)
                for (int b = 0; b < PAGE_BYTES; b++)
                    mem[p][b] <= '1;
        end else if (commit) begin
            for (int b = 0; b < PAGE_BYTES; b++)
                mem[wslot][b] <= vmask[b] ? bytes_flat[b*DATA_W +: DATA_W] : '1;
        end
    end

    assign rd_data = mem[rslot][rd_off];
endmodule

// File: rtl/page_load_buf.sv
module page_load_buf #(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128,
    parameter int ARR_PAGES  = 8,
    parameter int TIMEOUT    = 300,
    parameter int PROG_CYC   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              page_err
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;

    logic                         byte_evt, accept, commit;
    logic [ADDR_W-1:0]            byte_addr;
    logic [DATA_W-1:0]            byte_data;
    logic [PG_W-1:0]              open_page;
    logic [PAGE_BYTES-1:0]        vmask;
    logic [PAGE_BYTES*DATA_W-1:0] bytes_flat;

    pl_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .byte_evt(byte_evt),
        .byte_addr(byte_addr), .byte_data(byte_data)
    );

    pl_ctrl #(.PG_W(PG_W), .TIMEOUT(TIMEOUT), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_evt(byte_evt),
        .byte_page(byte_addr[ADDR_W-1:OFF_W]), .accept(accept),
        .commit(commit), .open_page(open_page), .busy(busy),
        .page_err(page_err)
    );

    pl_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .accept(accept), .commit(commit),
        .off(byte_addr[OFF_W-1:0]), .data(byte_data),
        .vmask(vmask), .bytes_flat(bytes_flat)
    );

    pl_array #(.PAGE_BYTES(PAGE_BYTES), .ARR_PAGES(ARR_PAGES),
               .DATA_W(DATA_W), .PG_W(PG_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .wr_page(open_page),
        .vmask(vmask), .bytes_flat(bytes_flat),
        .rd_page(rd_addr[ADDR_W-1:OFF_W]), .rd_off(rd_addr[OFF_W-1:0]),
        .rd_data(rd_data)
    );

    // R8
    busy_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(vmask));

    // R9
    commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (vmask == '0));

    // R5
    no_load_at_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(accept));

    // R7
    mismatch_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_evt && !busy && vmask != '0 && byte_addr[ADDR_W-1:OFF_W] != open_page)
            |=> $stable(vmask));
endmodule

// File: tb/sim_page_load_buf.sv
module sim_page_load_buf;
    localparam int TO = 300;
    localparam int PC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0, rd_addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  rd_data;
    logic        busy, page_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    page_load_buf #(.TIMEOUT(TO), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .page_err(page_err)
    );

    // {offset[6:0], data[7:0]} loaded into page 5 out of order
    localparam logic [14:0] VEC [6] = '{
        {7'h40, 8'hA1}, {7'h03, 8'h5C}, {7'h7F, 8'h00},
        {7'h00, 8'h3E}, {7'h21, 8'hC7}, {7'h10, 8'h18}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [16:0] a, input logic [7:0] d,
                          input logic [16:0] a2, input logic [7:0] d0);
        @(negedge clk); addr = a; din = d0; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = a2; din = d;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        strobe(a, d, a, d);
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #2; d = rd_data;
    endtask

    // counts negedges until busy high; returns -1 after lim
    task automatic until_busy(input int lim, output int n);
        n = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (busy) begin n = i; break; end
        end
    endtask

    task automatic until_idle(output int w);
        w = 0;
        while (busy && w < 1000) begin @(negedge clk); w++; end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 page_err", page_err, 0);
        rd({10'd3, 7'h22}, v); chk("R1 erased", v, 8'hFF);

        // R3 table walk: unordered loads into page 5
        foreach (VEC[i]) wr({10'd5, VEC[i][14:8]}, VEC[i][7:0]);
        until_busy(TO + 20, n);
        chk("R5 busy rises after idle", n >= 0, 1);
        until_idle(w);
        foreach (VEC[i]) begin
            rd({10'd5, VEC[i][14:8]}, v);
            chk("R3 byte placed", v, VEC[i][7:0]);
        end
        rd({10'd5, 7'h01}, v); chk("R4 unloaded FF", v, 8'hFF);
        rd({10'd5, 7'h7E}, v); chk("R4 unloaded FF", v, 8'hFF);

        // R5 restart and expiry time, R6 busy width
        wr({10'd2, 7'h00}, 8'h11);
        repeat (250) @(negedge clk);
        chk("R5 not expired", busy, 0);
        wr({10'd2, 7'h01}, 8'h12);
        until_busy(TO + 20, n);
        chk("R5 expiry window", (n >= TO - 8) && (n <= TO), 1);
        w = 0;
        while (busy && w < 1000) begin @(negedge clk); w++; end
        chk("R6 busy width", w, PC);
        rd({10'd2, 7'h00}, v); chk("R6 committed", v, 8'h11);
        rd({10'd2, 7'h01}, v); chk("R6 committed", v, 8'h12);

        // R7 mismatched page
        wr({10'd3, 7'h05}, 8'h33);
        repeat (200) @(negedge clk);
        wr({10'd4, 7'h05}, 8'h44);
        chk("R7 err set", page_err, 1);
        until_busy(TO, n);
        chk("R7 timer not extended", (n >= 0) && (n <= TO - 200), 1);
        until_idle(w);
        rd({10'd3, 7'h05}, v); chk("R7 open page kept", v, 8'h33);
        rd({10'd4, 7'h05}, v); chk("R7 dropped byte", v, 8'hFF);
        chk("R7 err sticky", page_err, 1);

        // R2 inhibits
        oe_n = 1'b0;
        wr({10'd6, 7'h09}, 8'h55);
        oe_n = 1'b1;
        @(negedge clk); addr = {10'd6, 7'h0A}; din = 8'h66; we_n = 1'b0;
        repeat (5) @(negedge clk); we_n = 1'b1;
        until_busy(TO + 20, n);
        chk("R2 no page opened", n, -1);
        rd({10'd6, 7'h09}, v); chk("R2 oe inhibit", v, 8'hFF);
        rd({10'd6, 7'h0A}, v); chk("R2 ce inhibit", v, 8'hFF);

        // R8 strobe during busy
        wr({10'd1, 7'h02}, 8'h77);
        until_busy(TO + 20, n);
        wr({10'd1, 7'h03}, 8'h88);
        until_idle(w);
        until_busy(TO + 20, n);
        chk("R8 no second pulse", n, -1);
        rd({10'd1, 7'h02}, v); chk("R8 first kept", v, 8'h77);
        rd({10'd1, 7'h03}, v); chk("R8 busy write ignored", v, 8'hFF);

        // R9 mask cleared: reload page 5 with one byte
        wr({10'd5, 7'h40}, 8'h99);
        until_busy(TO + 20, n);
        until_idle(w);
        rd({10'd5, 7'h40}, v); chk("R9 new byte", v, 8'h99);
        rd({10'd5, 7'h03}, v); chk("R9 old byte gone", v, 8'hFF);

        // R10 address at start, data at end
        strobe({10'd7, 7'h11}, 8'h7A, {10'd7, 7'h12}, 8'h6B);
        until_busy(TO + 20, n);
        until_idle(w);
        rd({10'd7, 7'h11}, v); chk("R10 start address, end data", v, 8'h7A);
        rd({10'd7, 7'h12}, v); chk("R10 late address unused", v, 8'hFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule